// File: doc/BRIEF.md
# Receive HDLC Length Guard

This block sits behind the receive HDLC de-framer of a multi-channel controller. Octets arrive one per cycle at most, already stripped of flags and destuffed. Each octet carries a channel number and start-of-packet and end-of-packet markers. The block keeps a running octet count for each channel. Every octet between the opening and closing flag counts toward it: address, control, payload and check-sequence octets alike.

One host-written 16-bit ceiling applies to every channel, together with an enable bit. While the enable bit is set, the first octet that takes a channel's count above the ceiling is not forwarded. Instead, it raises an abort pulse, and the channel enters a discard state. In that state each of its further octets produces only a discard strobe, until the channel's next start-of-packet. The verdict for each octet appears on registered outputs one clock after the octet is presented.

Top module: `hdlc_len_guard`

## Requirements
- R1: After reset, out_valid, out_abort and out_drop are 0, the ceiling register holds 0 and the enable bit is 0.
- R2: If the enable bit is written to 1 and the ceiling is never written after reset, the first octet of any packet is aborted, because the ceiling is 0.
- R3: While the enable bit is 0, octets of a channel that is not discarding are forwarded (out_valid=1) whatever the packet length.
- R4: With checking enabled, a packet whose octet count, start and end octets included, equals the ceiling is forwarded in full.
- R5: With checking enabled, the octet that raises a channel's count to ceiling+1 gives out_abort=1 and out_drop=1 with out_valid=0.
- R6: After an abort, each further octet of that channel gives out_drop=1 with out_valid=0 and out_abort=0, including its end-of-packet octet.
- R7: Counts are kept per channel, so interleaved packets on different channels are judged independently.
- R8: A start-of-packet octet restarts its channel's count at 1 and ends a discard state. With a ceiling of at least 1 it is forwarded.
- R9: Clearing the enable bit in the middle of a packet stops checking from the next octet onward.
- R10: A forwarded octet appears one clock after it is presented, with its channel, data, start and end markers unchanged.
- R11: A cycle with in_valid=0 gives out_valid, out_abort and out_drop all 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len_we | input | 1 | Write strobe for the ceiling register |
| cfg_len_wdata | input | 16 | New ceiling value |
| cfg_en_we | input | 1 | Write strobe for the enable bit |
| cfg_en_wdata | input | 1 | New enable value |
| in_valid | input | 1 | An octet is presented this cycle |
| in_chan | input | 8 | Channel of the octet |
| in_data | input | 8 | Octet value |
| in_sof | input | 1 | Octet is the first of a packet |
| in_eof | input | 1 | Octet is the last of a packet |
| out_valid | output | 1 | Forwarded octet |
| out_chan | output | 8 | Channel of the forwarded octet |
| out_data | output | 8 | Forwarded octet value |
| out_sof | output | 1 | Forwarded start marker |
| out_eof | output | 1 | Forwarded end marker |
| out_abort | output | 1 | Packet aborted on this octet for excess length |
| out_drop | output | 1 | Octet discarded |

## Verification
Every octet verdict is registered once, so the bench drives an octet on a falling edge and reads out_valid, out_abort, out_drop and the forwarded fields 1 ns after the following rising edge. A ceiling or enable write takes effect for octets presented on later edges. The bench therefore makes each write in a cycle with no octet and presents the next octet one cycle later. Idle cycles between scenarios are checked the same way, one edge after in_valid drops.

// File: rtl/hdlc_len_pkg.sv
package hdlc_len_pkg;
  typedef enum logic [1:0] {
    VERDICT_IDLE  = 2'd0,
    VERDICT_PASS  = 2'd1,
    VERDICT_ABORT = 2'd2,
    VERDICT_DROP  = 2'd3
  } verdict_t;
endpackage

// File: rtl/hdlc_len_ctx.sv
// Per-channel context store: running count plus discard flag.
// Synchronous write, asynchronous read (distributed RAM style);
// a resettable 'live' vector makes untouched channels read as zero.
module hdlc_len_ctx #(
  parameter int CH_W  = 8,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CH_W-1:0]  rd_chan,
  output logic [LEN_W-1:0] rd_cnt,
  output logic             rd_drop,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_chan,
  input  logic [LEN_W-1:0] wr_cnt,
  input  logic             wr_drop
);
  localparam int DEPTH = 1 << CH_W;
  localparam int WORD  = LEN_W + 1;

  logic [WORD-1:0]  mem [DEPTH];
  logic [DEPTH-1:0] live;
  logic [WORD-1:0]  rd_word;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_chan] <= {wr_drop, wr_cnt};
  end

  always_ff @(posedge clk) begin
    if (rst)        live <= '0;
    else if (wr_en) live[wr_chan] <= 1'b1;
  end

  assign rd_word = live[rd_chan] ? mem[rd_chan] : '0;
  assign rd_drop = rd_word[WORD-1];
  assign rd_cnt  = rd_word[LEN_W-1:0];
endmodule

// File: rtl/hdlc_len_judge.sv
// Combinational verdict for one octet given its channel context.
module hdlc_len_judge
  import hdlc_len_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             valid,
  input  logic             sof,
  input  logic             chk_en,
  input  logic [LEN_W-1:0] limit,
  input  logic [LEN_W-1:0] cur_cnt,
  input  logic             cur_drop,
  output verdict_t         verdict,
  output logic             wr,
  output logic [LEN_W-1:0] nxt_cnt,
  output logic             nxt_drop
);
  logic [LEN_W-1:0] base_cnt;
  logic             base_drop;
  logic [LEN_W:0]   next_wide;
  logic             over;

  always_comb begin
    base_cnt  = sof ? '0 : cur_cnt;
    base_drop = sof ? 1'b0 : cur_drop;
    next_wide = {1'b0, base_cnt} + {{LEN_W{1'b0}}, 1'b1};
    over      = next_wide > {1'b0, limit};
    verdict   = VERDICT_IDLE;
    wr        = 1'b0;
    nxt_cnt   = next_wide[LEN_W] ? base_cnt : next_wide[LEN_W-1:0];
    nxt_drop  = 1'b0;
    if (valid) begin
      if (base_drop) begin
        verdict = VERDICT_DROP;
      end else if (chk_en && over) begin
        verdict  = VERDICT_ABORT;
        wr       = 1'b1;
        nxt_drop = 1'b1;
      end else begin
        verdict = VERDICT_PASS;
        wr      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hdlc_len_guard.sv
module hdlc_len_guard
  import hdlc_len_pkg::*;
#(
  parameter int CH_W   = 8,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_len_we,
  input  logic [LEN_W-1:0]  cfg_len_wdata,
  input  logic              cfg_en_we,
  input  logic              cfg_en_wdata,
  input  logic              in_valid,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_chan,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic              out_abort,
  output logic              out_drop
);
  logic [LEN_W-1:0] max_len_q;
  logic             chk_en_q;
  logic [LEN_W-1:0] ctx_cnt;
  logic             ctx_drop;
  verdict_t         verdict;
  logic             ctx_wr;
  logic [LEN_W-1:0] ctx_nxt_cnt;
  logic             ctx_nxt_drop;

  always_ff @(posedge clk) begin
    if (rst) begin
      max_len_q <= '0;
      chk_en_q  <= 1'b0;
    end else begin
      if (cfg_len_we) max_len_q <= cfg_len_wdata;
      if (cfg_en_we)  chk_en_q  <= cfg_en_wdata;
    end
  end

  hdlc_len_ctx #(.CH_W(CH_W), .LEN_W(LEN_W)) u_ctx (
    .clk     (clk),
    .rst     (rst),
    .rd_chan (in_chan),
    .rd_cnt  (ctx_cnt),
    .rd_drop (ctx_drop),
    .wr_en   (ctx_wr),
    .wr_chan (in_chan),
    .wr_cnt  (ctx_nxt_cnt),
    .wr_drop (ctx_nxt_drop)
  );

  hdlc_len_judge #(.LEN_W(LEN_W)) u_judge (
    .valid    (in_valid),
    .sof      (in_sof),
    .chk_en   (chk_en_q),
    .limit    (max_len_q),
    .cur_cnt  (ctx_cnt),
    .cur_drop (ctx_drop),
    .verdict  (verdict),
    .wr       (ctx_wr),
    .nxt_cnt  (ctx_nxt_cnt),
    .nxt_drop (ctx_nxt_drop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_abort <= 1'b0;
      out_drop  <= 1'b0;
      out_chan  <= '0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
    end else begin
      out_valid <= (verdict == VERDICT_PASS);
      out_abort <= (verdict == VERDICT_ABORT);
      out_drop  <= (verdict == VERDICT_ABORT) || (verdict == VERDICT_DROP);
      if (in_valid) begin
        out_chan <= in_chan;
        out_data <= in_data;
        out_sof  <= in_sof;
        out_eof  <= in_eof;
      end
    end
  end
endmodule

// File: rtl/hdlc_len_guard_chk.sv
module hdlc_len_guard_chk #(
  parameter int CH_W  = 8,
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             chk_en_q,
  input logic [LEN_W-1:0] max_len_q,
  input logic             in_valid,
  input logic [CH_W-1:0]  in_chan,
  input logic             in_sof,
  input logic             out_valid,
  input logic [CH_W-1:0]  out_chan,
  input logic             out_sof,
  input logic             out_abort,
  input logic             out_drop
);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_abort && !out_drop));

  // R5
  abort_discards_chk: assert property (@(posedge clk) disable iff (rst)
    out_abort |-> (out_drop && !out_valid));

  // R6
  drop_not_forwarded_chk: assert property (@(posedge clk) disable iff (rst)
    out_drop |-> !out_valid);

  // R3
  unchecked_start_passes_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sof && !chk_en_q) |=> out_valid);

  // R8
  start_restarts_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sof && (max_len_q != '0)) |=> out_valid);

  // R10
  forward_fields_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sof && !chk_en_q) |=> (out_sof && out_chan == $past(in_chan)));
endmodule

bind hdlc_len_guard hdlc_len_guard_chk #(.CH_W(CH_W), .LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .chk_en_q  (chk_en_q),
  .max_len_q (max_len_q),
  .in_valid  (in_valid),
  .in_chan   (in_chan),
  .in_sof    (in_sof),
  .out_valid (out_valid),
  .out_chan  (out_chan),
  .out_sof   (out_sof),
  .out_abort (out_abort),
  .out_drop  (out_drop)
);

// File: tb/tb_hdlc_len_guard.sv
`timescale 1ns/1ps
module tb_hdlc_len_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_len_we = 1'b0;
  logic [15:0] cfg_len_wdata = '0;
  logic        cfg_en_we = 1'b0;
  logic        cfg_en_wdata = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_chan = '0;
  logic [7:0]  in_data = '0;
  logic        in_sof = 1'b0;
  logic        in_eof = 1'b0;
  logic        out_valid;
  logic [7:0]  out_chan;
  logic [7:0]  out_data;
  logic        out_sof;
  logic        out_eof;
  logic        out_abort;
  logic        out_drop;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  hdlc_len_guard dut (
    .clk(clk), .rst(rst),
    .cfg_len_we(cfg_len_we), .cfg_len_wdata(cfg_len_wdata),
    .cfg_en_we(cfg_en_we), .cfg_en_wdata(cfg_en_wdata),
    .in_valid(in_valid), .in_chan(in_chan), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof),
    .out_abort(out_abort), .out_drop(out_drop)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic set_len(input int v);
    @(negedge clk);
    in_valid = 1'b0; cfg_len_we = 1'b1; cfg_len_wdata = v[15:0];
    @(negedge clk);
    cfg_len_we = 1'b0;
  endtask

  task automatic set_en(input bit v);
    @(negedge clk);
    in_valid = 1'b0; cfg_en_we = 1'b1; cfg_en_wdata = v;
    @(negedge clk);
    cfg_en_we = 1'b0;
  endtask

  // present one octet, check its verdict one edge later
  task automatic oct(input int ch, input int d, input bit s, input bit e,
                     input bit ev, input bit ea, input bit ed, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_chan = ch[7:0]; in_data = d[7:0]; in_sof = s; in_eof = e;
    @(posedge clk);
    #1;
    chk(tag, "out_valid", out_valid, ev);
    chk(tag, "out_abort", out_abort, ea);
    chk(tag, "out_drop", out_drop, ed);
    if (ev) begin
      chk({tag, "/R10"}, "out_chan", out_chan, ch);
      chk({tag, "/R10"}, "out_data", out_data, d);
      chk({tag, "/R10"}, "out_sof", out_sof, s);
      chk({tag, "/R10"}, "out_eof", out_eof, e);
    end
  endtask

  task automatic idle_chk();
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    @(posedge clk);
    #1;
    chk("R11", "out_valid", out_valid, 0);
    chk("R11", "out_abort", out_abort, 0);
    chk("R11", "out_drop", out_drop, 0);
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "out_abort", out_abort, 0);
    chk("R1", "out_drop", out_drop, 0);
  endtask

  task automatic t_zero_ceiling();
    set_en(1'b1);
    oct(3, 8'h11, 1, 0, 0, 1, 1, "R2");
    oct(3, 8'h12, 0, 1, 0, 0, 1, "R2");
    oct(3, 8'h13, 1, 1, 0, 1, 1, "R2");
    idle_chk();
  endtask

  task automatic t_disabled();
    set_en(1'b0);
    set_len(2);
    oct(7, 8'h20, 1, 0, 1, 0, 0, "R3");
    for (int i = 1; i < 4; i++) oct(7, 8'h20 + i, 0, 0, 1, 0, 0, "R3");
    oct(7, 8'h2F, 0, 1, 1, 0, 0, "R3");
    idle_chk();
  endtask

  task automatic t_exact();
    set_len(4);
    set_en(1'b1);
    oct(9, 8'hA0, 1, 0, 1, 0, 0, "R4");
    oct(9, 8'hA1, 0, 0, 1, 0, 0, "R4");
    oct(9, 8'hA2, 0, 0, 1, 0, 0, "R4");
    oct(9, 8'hA3, 0, 1, 1, 0, 0, "R4");
    idle_chk();
  endtask

  task automatic t_overrun();
    set_len(3);
    oct(4, 8'h40, 1, 0, 1, 0, 0, "R5");
    oct(4, 8'h41, 0, 0, 1, 0, 0, "R5");
    oct(4, 8'h42, 0, 0, 1, 0, 0, "R5");
    oct(4, 8'h43, 0, 0, 0, 1, 1, "R5");
    oct(4, 8'h44, 0, 0, 0, 0, 1, "R6");
    oct(4, 8'h45, 0, 1, 0, 0, 1, "R6");
    idle_chk();
    oct(4, 8'h46, 0, 0, 0, 0, 1, "R6");
    oct(4, 8'h50, 1, 0, 1, 0, 0, "R8");
    oct(4, 8'h51, 0, 1, 1, 0, 0, "R8");
    idle_chk();
  endtask

  task automatic t_interleave();
    oct(1, 8'h61, 1, 0, 1, 0, 0, "R7");
    oct(2, 8'h71, 1, 0, 1, 0, 0, "R7");
    oct(1, 8'h62, 0, 0, 1, 0, 0, "R7");
    oct(2, 8'h72, 0, 0, 1, 0, 0, "R7");
    oct(1, 8'h63, 0, 0, 1, 0, 0, "R7");
    oct(2, 8'h73, 0, 1, 1, 0, 0, "R7");
    oct(1, 8'h64, 0, 0, 0, 1, 1, "R7");
    oct(1, 8'h65, 0, 1, 0, 0, 1, "R7");
    idle_chk();
  endtask

  task automatic t_disable_mid();
    set_len(2);
    oct(5, 8'h81, 1, 0, 1, 0, 0, "R9");
    oct(5, 8'h82, 0, 0, 1, 0, 0, "R9");
    set_en(1'b0);
    oct(5, 8'h83, 0, 0, 1, 0, 0, "R9");
    oct(5, 8'h84, 0, 1, 1, 0, 0, "R9");
    idle_chk();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_zero_ceiling();
    t_disabled();
    t_exact();
    t_overrun();
    t_interleave();
    t_disable_mid();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule